// File: doc/BRIEF.md
# Block-Transfer Mailbox Register Interface

This block is the controller-side register window of a byte-wide mailbox used to pass block-transfer messages between a management controller and a host. The controller reaches it through a small register bus: configuration, interrupt enable, interrupt status, a reserved slot, a command-coded control/status register, a data port and an interrupt mask. Writes to the data port fill an outbound buffer. A control command hands that buffer to a separate framer, which sees a one-cycle send strobe and reads the bytes through a side read port.

Inbound bytes arrive from a separate deframer as push strobes, followed by a message-ready strobe. A completed message raises the host-to-controller attention bit. If that interrupt is enabled, the block also sets a status bit and drives a level interrupt. The controller then reads the message back through the data port: the first read gives a length byte that the block builds itself, and the payload follows. The block tells the deframer when it can take bytes, and it cannot while the controller is busy or while an interrupting message is waiting to be read.

Top module: `bt_mailbox`

## Requirements
- R1: After reset, every register reads 0x00, the first data port read returns length 0, irq is low, rx_accept is high and tx_len is 0.
- R2: The registers at offsets 0x00 (configuration), 0x04 (interrupt enable), 0x0C (reserved) and 0x18 (interrupt mask) read back the last byte written to them.
- R3: The control register (offset 0x10) applies only one action per write, chosen by priority: bit0 clear write pointer, then bit1 rewind read pointer, then bit2 attention clear, then bit7 busy toggle, then bit3 send. The lower-priority bits in the same write are ignored.
- R4: Clear write pointer (control bit0) sets tx_len to 0.
- R5: Each write to the data port (offset 0x14) appends its byte at index tx_len of the outbound buffer, visible on tx_byte through tx_idx. Once 64 bytes are held, further writes are dropped.
- R6: A send command (control bit3) produces a single one-cycle tx_send pulse in the cycle after the write. tx_len is unchanged, and control bits 3 (controller-to-host attention) and 6 (host busy) read 0 afterwards.
- R7: Writing control bit7 toggles the controller-busy flag, which reads at bit7. While the flag is set, rx_accept is low and pushed inbound bytes are ignored.
- R8: Any control write that leaves controller busy clear empties the inbound message (length 0) and clears the waiting state, so rx_accept returns high.
- R9: After a rewind (control bit1), the first data port read returns the inbound length. Each later read returns the next payload byte, and reads beyond the length return 0.
- R10: A message-ready strobe with a non-empty inbound buffer sets control bit2. If interrupt enable bit0 is set, it also sets status bit0 (offset 0x08), raises irq and drops rx_accept until the next R8 reset. If the enable bit is clear, status, irq and rx_accept are unaffected.
- R11: A message-ready strobe is ignored when the inbound buffer is empty or when more than 64 bytes were pushed: control bit2 stays 0 and irq stays low.
- R12: A write to the status register clears the status bits that are 1 in the data and drives irq low.
- R13: Writing control bit2 alone clears the host-to-controller attention bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data port index) |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt to the controller |
| rx_push | input | 1 | Inbound payload byte strobe from the deframer |
| rx_byte | input | 8 | Inbound payload byte |
| rx_done | input | 1 | Inbound message-ready strobe |
| rx_accept | output | 1 | High when inbound bytes are taken |
| tx_send | output | 1 | One-cycle strobe handing the outbound buffer to the framer |
| tx_len | output | 7 | Outbound byte count |
| tx_idx | input | 6 | Outbound buffer read index from the framer |
| tx_byte | output | 8 | Outbound byte at tx_idx |

## Verification
Random-length inbound messages, including one that exactly fills the 64-byte buffer, are read back through the data port. This separates a correct length prefix and payload order from an off-by-one in the index, and it also checks the zero returned past the end. The same flow runs with the interrupt enable both set and clear, which shows whether attention, status, irq and flow control are tied to the enable as required. Control writes that set several bits at once show which action wins the priority. An empty message and a 65-byte message tell the ignore rules apart from normal completion, and an outbound fill past 64 bytes exercises the drop rule.

// File: rtl/bt_mbx_pkg.sv
package bt_mbx_pkg;

  localparam logic [2:0] IDX_CFG  = 3'd0;
  localparam logic [2:0] IDX_IEN  = 3'd1;
  localparam logic [2:0] IDX_IST  = 3'd2;
  localparam logic [2:0] IDX_RSV  = 3'd3;
  localparam logic [2:0] IDX_CTL  = 3'd4;
  localparam logic [2:0] IDX_DATA = 3'd5;
  localparam logic [2:0] IDX_MASK = 3'd6;

  localparam int B_CLR_WR = 0;
  localparam int B_CLR_RD = 1;
  localparam int B_H2B    = 2;
  localparam int B_B2H    = 3;
  localparam int B_BUSY   = 7;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CLR_WR,
    ACT_CLR_RD,
    ACT_H2B,
    ACT_BUSY,
    ACT_B2H
  } ctl_act_e;

  // Highest-priority command in one control write.
  function automatic ctl_act_e pick_action(input logic [7:0] d);
    if (d[B_CLR_WR])    return ACT_CLR_WR;
    else if (d[B_CLR_RD]) return ACT_CLR_RD;
    else if (d[B_H2B])  return ACT_H2B;
    else if (d[B_BUSY]) return ACT_BUSY;
    else if (d[B_B2H])  return ACT_B2H;
    else                return ACT_NONE;
  endfunction

endpackage

// File: rtl/bt_ctl_decode.sv
module bt_ctl_decode
  import bt_mbx_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output ctl_act_e   act
);
  always_comb begin
    act = wr_en ? pick_action(wdata) : ACT_NONE;
  end
endmodule

// File: rtl/bt_byte_buf.sv
module bt_byte_buf #(
  parameter int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       push_byte,
  output logic             full,
  output logic [LEN_W-1:0] len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);
  logic [7:0] mem [DEPTH];

  assign full    = (len == LEN_W'(DEPTH));
  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      len <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (push && !full) begin
      mem[len[IDX_W-1:0]] <= push_byte;
      len <= len + 1'b1;
    end
  end
endmodule

// File: rtl/bt_mailbox.sv
module bt_mailbox
  import bt_mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [4:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq,
  input  logic             rx_push,
  input  logic [7:0]       rx_byte,
  input  logic             rx_done,
  output logic             rx_accept,
  output logic             tx_send,
  output logic [LEN_W-1:0] tx_len,
  input  logic [IDX_W-1:0] tx_idx,
  output logic [7:0]       tx_byte
);
  logic [2:0] sel;
  logic       hit;
  assign sel = bus_addr[4:2];
  assign hit = (bus_addr[1:0] == 2'b00) && (sel <= IDX_MASK);

  logic ctl_wr, stat_wr, data_wr, data_rd;
  assign ctl_wr  = bus_wr && hit && (sel == IDX_CTL);
  assign stat_wr = bus_wr && hit && (sel == IDX_IST);
  assign data_wr = bus_wr && hit && (sel == IDX_DATA);
  assign data_rd = bus_rd && hit && (sel == IDX_DATA);

  logic [7:0] cfg_q, ien_q, ist_q, rsv_q, mask_q;
  logic       busy_q, h2b_q, waiting_q, in_ovf_q, pre_q, tx_send_q;
  logic [LEN_W-1:0] rd_idx_q;

  ctl_act_e act;
  bt_ctl_decode u_dec (.wr_en(ctl_wr), .wdata(bus_wdata), .act(act));

  logic act_clr_wr, act_clr_rd, act_h2b, act_busy, act_b2h;
  assign act_clr_wr = (act == ACT_CLR_WR);
  assign act_clr_rd = (act == ACT_CLR_RD);
  assign act_h2b    = (act == ACT_H2B);
  assign act_busy   = (act == ACT_BUSY);
  assign act_b2h    = (act == ACT_B2H);

  logic busy_next, rx_reset;
  assign busy_next = busy_q ^ act_busy;
  assign rx_reset  = ctl_wr && !busy_next;
  assign rx_accept = !waiting_q && !busy_q;

  logic             out_full, in_full;
  logic [LEN_W-1:0] in_len;
  logic [7:0]       in_rd_byte;
  logic             push_try, msg_ok, irq_set;

  assign push_try = rx_push && rx_accept && !rx_reset;
  assign msg_ok   = rx_done && rx_accept && !rx_reset &&
                    (in_len != '0) && !in_ovf_q;
  assign irq_set  = msg_ok && ien_q[0];

  bt_byte_buf #(.DEPTH(DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(act_clr_wr),
    .push(data_wr && !out_full), .push_byte(bus_wdata),
    .full(out_full), .len(tx_len), .rd_idx(tx_idx), .rd_byte(tx_byte)
  );

  bt_byte_buf #(.DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset),
    .push(push_try && !in_full), .push_byte(rx_byte),
    .full(in_full), .len(in_len), .rd_idx(rd_idx_q[IDX_W-1:0]),
    .rd_byte(in_rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; ien_q <= '0; ist_q <= '0; rsv_q <= '0; mask_q <= '0;
      busy_q <= 1'b0; h2b_q <= 1'b0; waiting_q <= 1'b0; in_ovf_q <= 1'b0;
      pre_q <= 1'b1; rd_idx_q <= '0; tx_send_q <= 1'b0; irq <= 1'b0;
    end else begin
      if (bus_wr && hit && sel == IDX_CFG)  cfg_q  <= bus_wdata;
      if (bus_wr && hit && sel == IDX_IEN)  ien_q  <= bus_wdata;
      if (bus_wr && hit && sel == IDX_RSV)  rsv_q  <= bus_wdata;
      if (bus_wr && hit && sel == IDX_MASK) mask_q <= bus_wdata;

      ist_q <= (stat_wr ? (ist_q & ~bus_wdata) : ist_q) | {7'b0, irq_set};
      if (irq_set)      irq <= 1'b1;
      else if (stat_wr) irq <= 1'b0;

      busy_q    <= busy_next;
      tx_send_q <= act_b2h;

      if (msg_ok)       h2b_q <= 1'b1;
      else if (act_h2b) h2b_q <= 1'b0;

      if (rx_reset)     waiting_q <= 1'b0;
      else if (irq_set) waiting_q <= 1'b1;

      if (rx_reset)                 in_ovf_q <= 1'b0;
      else if (push_try && in_full) in_ovf_q <= 1'b1;

      if (act_clr_rd) begin
        pre_q    <= 1'b1;
        rd_idx_q <= '0;
      end else if (data_rd) begin
        if (pre_q)                pre_q    <= 1'b0;
        else if (rd_idx_q < in_len) rd_idx_q <= rd_idx_q + 1'b1;
      end
    end
  end

  assign tx_send = tx_send_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) begin
      case (sel)
        IDX_CFG:  bus_rdata = cfg_q;
        IDX_IEN:  bus_rdata = ien_q;
        IDX_IST:  bus_rdata = ist_q;
        IDX_RSV:  bus_rdata = rsv_q;
        IDX_CTL:  bus_rdata = {busy_q, 4'b0000, h2b_q, 2'b00};
        IDX_DATA: bus_rdata = pre_q ? 8'(in_len)
                            : ((rd_idx_q < in_len) ? in_rd_byte : 8'h00);
        IDX_MASK: bus_rdata = mask_q;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/bt_mailbox_chk.sv
module bt_mailbox_chk #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ien0,
  input logic             stat_wr,
  input logic             msg_ok,
  input logic             busy,
  input logic             rx_accept,
  input logic             tx_send,
  input logic             act_b2h,
  input logic             act_clr_wr,
  input logic [LEN_W-1:0] tx_len
);
  // R12
  stat_clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !msg_ok) |=> !irq);

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien0));

  // R7
  busy_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_accept);

  // R6
  send_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_b2h |=> tx_send);

  // R6
  send_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |=> !tx_send);

  // R5
  tx_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len <= LEN_W'(DEPTH));

  // R4
  clr_wr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr_wr |=> (tx_len == '0));
endmodule

bind bt_mailbox bt_mailbox_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ien0(ien_q[0]), .stat_wr(stat_wr),
  .msg_ok(msg_ok), .busy(busy_q), .rx_accept(rx_accept), .tx_send(tx_send),
  .act_b2h(act_b2h), .act_clr_wr(act_clr_wr), .tx_len(tx_len)
);

// File: tb/tb_bt_mailbox.sv
module tb_bt_mailbox;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, rx_push = 0, rx_done = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_byte = '0, bus_rdata, tx_byte;
  logic irq, rx_accept, tx_send;
  logic [6:0] tx_len;
  logic [5:0] tx_idx = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_mailbox dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic done();
    @(negedge clk); rx_done = 1;
    @(negedge clk); rx_done = 0;
  endtask

  function automatic logic [7:0] ctl_expect(input bit busy, input bit h2b);
    return {busy, 4'b0, h2b, 2'b0};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hang expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_msg [64];
    logic [7:0] outq [64];
    int n, len;
    bit en;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a <= 6; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 rx_accept", rx_accept, 1);
    chk("R1 tx_len", tx_len, 0);

    // R2 plain registers
    for (int k = 0; k < 4; k++) begin
      logic [4:0] a;
      logic [7:0] d;
      a = (k == 0) ? 5'h00 : (k == 1) ? 5'h04 : (k == 2) ? 5'h0C : 5'h18;
      d = 8'($urandom);
      wr(a, d);
      rd(a, v);
      chk("R2 readback", v, d);
    end

    // R5 outbound fill, random bytes
    wr(5'h10, 8'h01);
    chk("R4 clear", tx_len, 0);
    n = $urandom % 20 + 1;
    for (int i = 0; i < n; i++) begin
      outq[i] = 8'($urandom);
      wr(5'h14, outq[i]);
    end
    chk("R5 len", tx_len, n);
    for (int i = 0; i < n; i++) begin
      tx_idx = 6'(i); #1;
      chk("R5 byte", tx_byte, outq[i]);
    end

    // R6 send
    wr(5'h10, 8'h08);
    chk("R6 send pulse", tx_send, 1);
    @(negedge clk);
    chk("R6 send single", tx_send, 0);
    chk("R6 len kept", tx_len, n);
    rd(5'h10, v);
    chk("R6 ctl bits", v & 8'h48, 0);

    // R3 priority: clear-wr beats rewind and send
    wr(5'h10, 8'h0B);
    chk("R3 clr wins len", tx_len, 0);
    chk("R3 no send", tx_send, 0);

    // R5 overflow of outbound
    for (int i = 0; i < 70; i++) begin
      if (i < 64) outq[i] = 8'(i + 3);
      wr(5'h14, 8'(i + 3));
    end
    chk("R5 cap", tx_len, 64);
    tx_idx = 6'd63; #1;
    chk("R5 last kept", tx_byte, outq[63]);

    // inbound messages
    for (int it = 0; it < 4; it++) begin
      en = (it != 2);
      wr(5'h04, {7'b0, en});
      len = (it == 3) ? 64 : ($urandom % 30 + 1);
      for (int i = 0; i < len; i++) begin
        exp_msg[i] = 8'($urandom);
        push(exp_msg[i]);
      end
      done();
      rd(5'h10, v);
      chk("R10 h2b set", v, ctl_expect(0, 1));
      rd(5'h08, v);
      chk("R10 status", v, en ? 1 : 0);
      chk("R10 irq", irq, en);
      chk("R10 rx_accept", rx_accept, !en);
      if (en) push(8'h5A); // ignored while waiting
      wr(5'h10, 8'h80);
      chk("R7 busy blocks", rx_accept, 0);
      push(8'hA5); // ignored while busy
      if (it == 0) begin
        wr(5'h10, 8'h84);
        rd(5'h10, v);
        chk("R3 h2b beats busy", v, ctl_expect(1, 0));
      end else begin
        wr(5'h10, 8'h04);
        rd(5'h10, v);
        chk("R13 h2b clear", v, ctl_expect(1, 0));
      end
      wr(5'h10, 8'h02);
      rd(5'h14, v);
      chk("R9 length", v, len);
      for (int i = 0; i < len; i++) begin
        rd(5'h14, v);
        chk("R9 payload", v, exp_msg[i]);
      end
      rd(5'h14, v);
      chk("R9 past end", v, 0);
      wr(5'h08, 8'hFF);
      rd(5'h08, v);
      chk("R12 status clear", v, 0);
      chk("R12 irq low", irq, 0);
      wr(5'h10, 8'h80);
      chk("R8 accept back", rx_accept, 1);
      wr(5'h10, 8'h02);
      rd(5'h14, v);
      chk("R8 length zero", v, 0);
    end

    // R11 empty message
    wr(5'h04, 8'h01);
    done();
    rd(5'h10, v);
    chk("R11 empty h2b", v, 0);
    chk("R11 empty irq", irq, 0);

    // R11 overflowed message
    for (int i = 0; i < 65; i++) push(8'(i));
    done();
    rd(5'h10, v);
    chk("R11 ovf h2b", v, 0);
    chk("R11 ovf irq", irq, 0);

    finish_run();
  end
endmodule